// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block sits next to an I2C bus engine and decides what a software start request turns into. When the bus is idle, the request becomes a start-generate pulse on the next clock. The bus may instead be occupied by another master while this device takes no part in the transfer. In that case the request is held as a reservation, and the start is issued by itself on the first stop condition seen on the bus. Software therefore never has to poll and retry.

The block follows whether the bus is idle and whether this device is taking part as master or slave. It drives a master-status flag and runs a wait timer whose length comes from a 4-bit clock/mode code; software reads the status flag once the timer has run out. Transmit data written while a reservation is pending is treated as stale: it is never presented to the shifter. Pin drivers and the byte shifter sit outside the block.

Top module: `i2c_start_resv`

## Requirements
- R1: After reset, `resv_pending`=0, `master_status`=0, `bus_free`=1, `gen_start`=0, `stop_irq`=0, `wait_busy`=0 and `tx_valid`=0.
- R2: `start_req_set` while `bus_free`=1 gives a `gen_start` pulse one cycle wide on the next clock. On that same clock `master_status` becomes 1 and `bus_free` becomes 0.
- R3: `start_req_set` takes effect as a reservation only if all of these hold: `bus_free`=0, the device is neither master nor slave, and `resv_dis`=0. Then `resv_pending` becomes 1 and there is no `gen_start`.
- R4: With `resv_dis`=1, the reservation feature is off (it is enabled only at 0). A request made while the bus is busy is dropped and `resv_pending` stays 0.
- R5: A request made while the device is master or slave on a busy bus is dropped. An `arb_lost` pulse ends that participation, and a later request then reserves.
- R6: An addressed slave stops taking part only on `release_req` after `ext_code_rx` was seen with `slave_ack_dis`=1. `release_req` without that extension code leaves it taking part.
- R7: `bus_stop_det` while a reservation is pending gives a `gen_start` pulse on the next clock. On that clock `resv_pending` becomes 0 and `master_status` becomes 1. `stop_irq` pulses on any stop only when `stop_irq_en`=1.
- R8: `shift_wr` while no reservation is pending sets `tx_valid`=1 and `tx_data` to the written byte. Accepting a reservation clears `tx_valid`. A `shift_wr` while the reservation is pending leaves `tx_valid`=0.
- R9: After `start_req_set`, `wait_busy` is 1 for exactly N cycles. N depends on `wait_code` as follows: codes 0 to 8 give 12, 18, 30, 34, 36, 46, 60, 86, 172, and codes 9 to 15 give 172.
- R10: A pending reservation is cancelled by `start_req_clr` or `addr_match`. A following stop then produces no `gen_start`.
- R11: `master_status` returns to 0 on `arb_lost`, or on a stop that fires no reserved start.
- R12: `bus_start_det` makes `bus_free` 0 and `bus_stop_det` makes it 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resv_dis | input | 1 | 1 disables reservation |
| start_req_set | input | 1 | Software start request pulse |
| start_req_clr | input | 1 | Software clears the request |
| release_req | input | 1 | Software bus release pulse |
| stop_irq_en | input | 1 | Enables the stop interrupt |
| wait_code | input | 4 | Clock/mode code selecting the wait period |
| shift_wr | input | 1 | Software write to the shift register |
| shift_data | input | 8 | Byte written |
| bus_start_det | input | 1 | Start condition detected |
| bus_stop_det | input | 1 | Stop condition detected |
| arb_lost | input | 1 | Arbitration left the device neither master nor slave |
| ext_code_rx | input | 1 | Extension code received |
| slave_ack_dis | input | 1 | Slave acknowledge disabled |
| addr_match | input | 1 | Device addressed as slave |
| gen_start | output | 1 | Start-generate pulse to the bus engine |
| stop_irq | output | 1 | Stop interrupt pulse |
| master_status | output | 1 | Device is master |
| wait_busy | output | 1 | Wait period still running |
| resv_pending | output | 1 | Reservation held |
| bus_free | output | 1 | Bus seen as released |
| tx_valid | output | 1 | Shift data may be transmitted |
| tx_data | output | 8 | Byte for transmission |

## Verification
Suppose the participation state is wrong, for example a slave still treated as active after a valid release. Then a request that should reserve is dropped, and `resv_pending` stays 0 on the clock right after the request. A wrong pending bit shows up one clock after the next stop, either as a missing or an extra `gen_start`, or as a `master_status` that disagrees with it. A wrong wait lookup or counter shows up as a `wait_busy` high time that differs from the table value. That difference becomes visible only when the period ends, up to 172 cycles after the request.

// File: rtl/i2c_resv_pkg.sv
// Shared constants and the wait-period lookup for the start reservation block.
// Assumes a 4-bit clock/mode code; unused codes fall back to the longest wait.
package i2c_resv_pkg;
    localparam int CODE_W   = 4;
    localparam int WAIT_MAX = 172;
    localparam int WCNT_W   = $clog2(WAIT_MAX + 1);

    // Map a clock/mode code to its wait period in clocks.
    function automatic logic [WCNT_W-1:0] wait_lookup(input logic [CODE_W-1:0] code);
        logic [WCNT_W-1:0] n;
        case (code)
            4'd0:    n = WCNT_W'(12);
            4'd1:    n = WCNT_W'(18);
            4'd2:    n = WCNT_W'(30);
            4'd3:    n = WCNT_W'(34);
            4'd4:    n = WCNT_W'(36);
            4'd5:    n = WCNT_W'(46);
            4'd6:    n = WCNT_W'(60);
            4'd7:    n = WCNT_W'(86);
            default: n = WCNT_W'(WAIT_MAX);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/i2c_resv_bus_track.sv
// Tracks bus occupancy and whether this device takes part in the transfer.
// Assumes detect inputs are single-cycle pulses from the bus engine.
module i2c_resv_bus_track (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start_det,
    input  logic bus_stop_det,
    input  logic fire,
    input  logic arb_lost,
    input  logic ext_code_rx,
    input  logic slave_ack_dis,
    input  logic release_req,
    input  logic addr_match,
    output logic bus_free,
    output logic own_active
);
    logic ext_seen;

    // Bus idle flag: our own start or a foreign start occupies, stop frees.
    always_ff @(posedge clk) begin
        if (!rst_n)                     bus_free <= 1'b1;
        else if (bus_start_det || fire) bus_free <= 1'b0;
        else if (bus_stop_det)          bus_free <= 1'b1;
    end

    // Remembers an unacknowledged extension code until release or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ext_seen <= 1'b0;
        else if (bus_stop_det || release_req)     ext_seen <= 1'b0;
        else if (ext_code_rx && slave_ack_dis)    ext_seen <= 1'b1;
    end

    // Participation: master after our start, slave after address match.
    always_ff @(posedge clk) begin
        if (!rst_n)                     own_active <= 1'b0;
        else if (fire || addr_match)    own_active <= 1'b1;
        else if (arb_lost || bus_stop_det || (release_req && ext_seen))
                                        own_active <= 1'b0;
    end

    // R12: the bus only becomes free in response to a stop condition
    a_r12_free_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(bus_stop_det));

    // R6: participation only ends on arbitration loss, stop or a valid release
    a_r6_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_active) |-> $past(arb_lost || bus_stop_det || release_req));
endmodule

// File: rtl/i2c_resv_wait_timer.sv
// Loads the wait period for the current clock/mode code on each start request
// and counts it down; busy while non-zero. Assumes code is stable at request.
module i2c_resv_wait_timer
    import i2c_resv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              busy
);
    logic [WCNT_W-1:0] cnt;

    // Down-counter reloaded by every start request.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= wait_lookup(code);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R9: the counter never exceeds the longest period
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= WCNT_W'(WAIT_MAX));

    // R9: a request always starts a wait period
    a_r9_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
endmodule

// File: rtl/i2c_resv_txguard.sv
// Holds the transmit byte and its valid flag; bytes written while a
// reservation is pending are discarded as stale.
module i2c_resv_txguard #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_wr,
    input  logic [DATA_W-1:0] shift_data,
    input  logic              resv_pend,
    input  logic              resv_take,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    // Valid flag: cleared when a reservation is taken or by a stale write.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_valid <= 1'b0;
        else if (resv_take) tx_valid <= 1'b0;
        else if (shift_wr)  tx_valid <= !resv_pend;
    end

    // Byte register: captures only writes that are allowed to go out.
    always_ff @(posedge clk) begin
        if (!rst_n)                       tx_data <= '0;
        else if (shift_wr && !resv_pend)  tx_data <= shift_data;
    end

    // R8: data becomes valid only from a write made without a reservation
    a_r8_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(shift_wr && !resv_pend));
endmodule

// File: rtl/i2c_start_resv.sv
// Start reservation controller: turns a software start request into an
// immediate start on an idle bus, or a reservation fired on the next stop.
// Assumes all event and software inputs are single-cycle pulses.
module i2c_start_resv
    import i2c_resv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resv_dis,
    input  logic              start_req_set,
    input  logic              start_req_clr,
    input  logic              release_req,
    input  logic              stop_irq_en,
    input  logic [CODE_W-1:0] wait_code,
    input  logic              shift_wr,
    input  logic [DATA_W-1:0] shift_data,
    input  logic              bus_start_det,
    input  logic              bus_stop_det,
    input  logic              arb_lost,
    input  logic              ext_code_rx,
    input  logic              slave_ack_dis,
    input  logic              addr_match,
    output logic              gen_start,
    output logic              stop_irq,
    output logic              master_status,
    output logic              wait_busy,
    output logic              resv_pending,
    output logic              bus_free,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data
);
    logic own_active;
    logic fire_now, fire_auto, fire, resv_take;

    assign fire_now  = start_req_set && bus_free;
    assign fire_auto = bus_stop_det && resv_pending;
    assign fire      = fire_now || fire_auto;
    assign resv_take = start_req_set && !bus_free && !own_active
                       && !resv_dis && !resv_pending;

    i2c_resv_bus_track u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_start_det (bus_start_det),
        .bus_stop_det  (bus_stop_det),
        .fire          (fire),
        .arb_lost      (arb_lost),
        .ext_code_rx   (ext_code_rx),
        .slave_ack_dis (slave_ack_dis),
        .release_req   (release_req),
        .addr_match    (addr_match),
        .bus_free      (bus_free),
        .own_active    (own_active)
    );

    i2c_resv_wait_timer u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_req_set),
        .code  (wait_code),
        .busy  (wait_busy)
    );

    i2c_resv_txguard #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_wr   (shift_wr),
        .shift_data (shift_data),
        .resv_pend  (resv_pending),
        .resv_take  (resv_take),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data)
    );

    // Reservation flag: taken on a busy-bus request, dropped by fire or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     resv_pending <= 1'b0;
        else if (fire_auto || start_req_clr || addr_match) resv_pending <= 1'b0;
        else if (resv_take)                             resv_pending <= 1'b1;
    end

    // Start pulse toward the bus engine, one cycle per fire.
    always_ff @(posedge clk) begin
        if (!rst_n) gen_start <= 1'b0;
        else        gen_start <= fire;
    end

    // Stop interrupt pulse when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_irq <= 1'b0;
        else        stop_irq <= bus_stop_det && stop_irq_en;
    end

    // Master flag: set by any start we issue, cleared by loss or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                          master_status <= 1'b0;
        else if (fire)                       master_status <= 1'b1;
        else if (arb_lost || bus_stop_det)   master_status <= 1'b0;
    end

    // R2: every start pulse comes with the master flag
    a_r2_start_is_master: assert property (@(posedge clk) disable iff (!rst_n)
        gen_start |-> master_status);

    // R3: a reservation and master operation never coexist
    a_r3_resv_not_master: assert property (@(posedge clk) disable iff (!rst_n)
        !(resv_pending && master_status));

    // R4: no reservation is taken while the feature is disabled
    a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resv_pending) |-> $past(!resv_dis));

    // R7: stop interrupt only when enabled
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> $past(stop_irq_en && bus_stop_det));
endmodule

// File: tb/i2c_start_resv_tb_top.sv
module i2c_start_resv_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic resv_dis = 0, start_req_set = 0, start_req_clr = 0, release_req = 0;
    logic stop_irq_en = 0;
    logic [3:0] wait_code = 0;
    logic shift_wr = 0;
    logic [7:0] shift_data = 0;
    logic bus_start_det = 0, bus_stop_det = 0, arb_lost = 0;
    logic ext_code_rx = 0, slave_ack_dis = 0, addr_match = 0;
    logic gen_start, stop_irq, master_status, wait_busy, resv_pending, bus_free, tx_valid;
    logic [7:0] tx_data;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    i2c_start_resv dut_i (
        .clk(clk), .rst_n(rst_n), .resv_dis(resv_dis), .start_req_set(start_req_set),
        .start_req_clr(start_req_clr), .release_req(release_req), .stop_irq_en(stop_irq_en),
        .wait_code(wait_code), .shift_wr(shift_wr), .shift_data(shift_data),
        .bus_start_det(bus_start_det), .bus_stop_det(bus_stop_det), .arb_lost(arb_lost),
        .ext_code_rx(ext_code_rx), .slave_ack_dis(slave_ack_dis), .addr_match(addr_match),
        .gen_start(gen_start), .stop_irq(stop_irq), .master_status(master_status),
        .wait_busy(wait_busy), .resv_pending(resv_pending), .bus_free(bus_free),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input int code);
        case (code)
            0: return 12;  1: return 18;  2: return 30;  3: return 34;
            4: return 36;  5: return 46;  6: return 60;  7: return 86;
            default: return 172;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk);
        start_req_set = 0; start_req_clr = 0; release_req = 0; shift_wr = 0;
        bus_start_det = 0; bus_stop_det = 0; arb_lost = 0; ext_code_rx = 0; addr_match = 0;
    endtask

    task automatic foreign_start(); bus_start_det = 1; step(); endtask
    task automatic request();       start_req_set = 1; step(); endtask
    task automatic stop();          bus_stop_det = 1; step(); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 resv", resv_pending, 0); check("R1 master", master_status, 0);
        check("R1 free", bus_free, 1);     check("R1 gen", gen_start, 0);
        check("R1 busy", wait_busy, 0);    check("R1 txv", tx_valid, 0);
        check("R1 irq", stop_irq, 0);

        // R2 immediate start on free bus
        request();
        check("R2 gen", gen_start, 1); check("R2 master", master_status, 1);
        check("R2 free", bus_free, 0);
        step();
        check("R2 pulse width", gen_start, 0);
        // R5 request while master on busy bus is dropped
        request();
        check("R5 ignored resv", resv_pending, 0); check("R5 ignored gen", gen_start, 0);
        arb_lost = 1; step();
        check("R11 arb clears master", master_status, 0);
        request();
        check("R5 reserve after loss", resv_pending, 1);

        // R11 stop without reservation clears master, R12 free
        do_reset();
        request(); step();
        stop();
        check("R11 stop clears master", master_status, 0);
        check("R12 stop frees", bus_free, 1);
        check("R7 irq off", stop_irq, 0);
        foreign_start();
        check("R12 start busies", bus_free, 0);

        // R3 reservation, R7 fire on stop with irq
        do_reset();
        foreign_start();
        request();
        check("R3 resv", resv_pending, 1); check("R3 no gen", gen_start, 0);
        check("R3 master", master_status, 0);
        stop_irq_en = 1;
        stop();
        check("R7 gen", gen_start, 1); check("R7 irq", stop_irq, 1);
        check("R7 resv cleared", resv_pending, 0); check("R7 master", master_status, 1);
        check("R7 bus busy", bus_free, 0);
        stop_irq_en = 0;

        // R4 disabled reservation
        do_reset();
        resv_dis = 1;
        foreign_start();
        request();
        check("R4 no resv", resv_pending, 0);
        stop();
        check("R4 no gen", gen_start, 0);
        resv_dis = 0;

        // R6 slave release rules
        do_reset();
        foreign_start();
        addr_match = 1; step();
        request();
        check("R6 slave ignored", resv_pending, 0);
        release_req = 1; step();
        request();
        check("R6 plain release ignored", resv_pending, 0);
        slave_ack_dis = 1; ext_code_rx = 1; step();
        release_req = 1; step();
        slave_ack_dis = 0;
        request();
        check("R6 ext release reserves", resv_pending, 1);

        // R10 cancellation
        do_reset();
        foreign_start(); request();
        start_req_clr = 1; step();
        check("R10 clr cancels", resv_pending, 0);
        stop();
        check("R10 no gen after clr", gen_start, 0);
        foreign_start(); request();
        addr_match = 1; step();
        check("R10 addr cancels", resv_pending, 0);

        // R8 transmit data guarding
        do_reset();
        shift_wr = 1; shift_data = 8'hA5; step();
        check("R8 valid", tx_valid, 1); check("R8 data", tx_data, 8'hA5);
        foreign_start(); request();
        check("R8 cleared by resv", tx_valid, 0);
        shift_wr = 1; shift_data = 8'h3C; step();
        check("R8 stale write", tx_valid, 0);
        stop(); step();
        shift_wr = 1; shift_data = 8'h5A; step();
        check("R8 after stop valid", tx_valid, 1); check("R8 after stop data", tx_data, 8'h5A);

        // R9 sweep of every wait code
        for (int c = 0; c < 16; c++) begin
            int n;
            do_reset();
            wait_code = 4'(c);
            request();
            n = 0;
            while (wait_busy && n < 300) begin n++; @(negedge clk); end
            check($sformatf("R9 code %0d", c), n, exp_wait(c));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule